// File: doc/BRIEF.md
# Two-Thread Core Operating Mode Controller

This block decides how a core that carries two hardware threads is running at any moment. Both threads may be live, only thread 0 or only thread 1 may be live, or neither, in which case the core sits in a low-power state. Each thread reports that it has halted with a one-cycle pulse. An interrupt aimed at a thread that is not running is also a one-cycle pulse, and it wakes that thread. The block presents the current mode, a low-power enable, and the allocation of the core's partitioned queues.

When both threads run, every partitioned queue is split between them. When one thread runs alone, it receives every entry. Each mode change raises a one-cycle drain request towards the pipeline. The queues keep their old allocation until the pipeline reports that the drain is complete. Only then does the allocation move to match the mode that is current at that point. The block outputs the entry budget per thread so that the queue logic can enforce the allocation directly.

Top module: `mt_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `core_mode` is 2'b00 (both threads), `low_power_en` is 0, `drain_req` is 0 and `alloc_mode` is 2'b00 (split).
- R2: `core_mode` uses 2'b00 for both threads, 2'b01 for thread 0 alone, 2'b10 for thread 1 alone and 2'b11 for low power. In 2'b00, a halt pulse on one thread alone (`halt_pulse` bit i is thread i) moves the mode to single-thread for the other thread on the next cycle.
- R3: In 2'b00, halt pulses from both threads in the same cycle move the mode directly to 2'b11.
- R4: In a single-thread mode, a halt by the running thread moves the mode to 2'b11. A halt pulse from the thread that is already halted is ignored.
- R5: In a single-thread mode, an interrupt for the halted thread (`irq_pulse` bit i is thread i) moves the mode to 2'b00. If that interrupt arrives in the same cycle as a halt by the running thread, the mode moves to single-thread for the woken thread.
- R6: In 2'b11, an interrupt for one thread enters single-thread mode for that thread, and interrupts for both threads enter 2'b00. Halt pulses are ignored.
- R7: Interrupts aimed at a running thread are ignored. This covers any interrupt in 2'b00 and an interrupt for the active thread in a single-thread mode.
- R8: `low_power_en` is 1 exactly when `core_mode` is 2'b11.
- R9: `drain_req` is high for exactly the first cycle after each mode change and is low at all other times.
- R10: `alloc_mode` uses the same encoding as `core_mode`, with 2'b11 meaning no entries for either thread. It changes only on a `drain_done` that arrives while a drain is outstanding and not on a cycle where the mode changes. It then takes the current mode. Any other `drain_done` is ignored.
- R11: For allocation 2'b00, `cap_t0` and `cap_t1` split QUEUE_DEPTH, and the odd entry goes to thread 0 when ODD_TO_T0 is 1. For 2'b01 and 2'b10, the active thread receives QUEUE_DEPTH and the other thread receives 0. For 2'b11, both receive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_pulse | input | 2 | Per-thread halt event, one cycle |
| irq_pulse | input | 2 | Per-thread interrupt event, one cycle |
| drain_done | input | 1 | Pipeline reports the drain is complete |
| core_mode | output | 2 | Current operating mode |
| low_power_en | output | 1 | Low-power state enable |
| drain_req | output | 1 | One-cycle drain request after a mode change |
| alloc_mode | output | 2 | Queue allocation currently in force |
| cap_t0 | output | $clog2(QUEUE_DEPTH+1) | Entry budget for thread 0 |
| cap_t1 | output | $clog2(QUEUE_DEPTH+1) | Entry budget for thread 1 |

## Verification
The bench builds the block with QUEUE_DEPTH = 7 and ODD_TO_T0 = 1. With an odd depth, the split budget is 4/3, so a swapped or truncated split is visible at the ports, and a 3-bit budget field makes a full-depth grant of 7 use every bit. The stimulus table walks every mode through each event combination: single and simultaneous halts, interrupts on running and halted threads, and a halt that coincides with a wake-up. It also times `drain_done` before, during and after a mode change, so that the allocation hold can be told apart from an immediate repartition.

// File: rtl/mt_mode_pkg.sv
package mt_mode_pkg;

   typedef enum logic [1:0] {
      MODE_DUAL  = 2'b00,
      MODE_SOLO0 = 2'b01,
      MODE_SOLO1 = 2'b10,
      MODE_SLEEP = 2'b11
   } core_mode_e;

endpackage

// File: rtl/mt_mode_fsm.sv
module mt_mode_fsm
   import mt_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] halt_pulse,
   input  logic [1:0] irq_pulse,
   output core_mode_e mode_q,
   output logic       mode_chg,
   output logic       lp_q,
   output logic       drain_q
);

   core_mode_e mode_nx;

   always_comb begin
      mode_nx = mode_q;
      unique case (mode_q)
         MODE_DUAL: begin
            if (halt_pulse == 2'b11)  mode_nx = MODE_SLEEP;
            else if (halt_pulse[0])   mode_nx = MODE_SOLO1;
            else if (halt_pulse[1])   mode_nx = MODE_SOLO0;
         end
         MODE_SOLO0: begin
            if (halt_pulse[0] && irq_pulse[1]) mode_nx = MODE_SOLO1;
            else if (halt_pulse[0])            mode_nx = MODE_SLEEP;
            else if (irq_pulse[1])             mode_nx = MODE_DUAL;
         end
         MODE_SOLO1: begin
            if (halt_pulse[1] && irq_pulse[0]) mode_nx = MODE_SOLO0;
            else if (halt_pulse[1])            mode_nx = MODE_SLEEP;
            else if (irq_pulse[0])             mode_nx = MODE_DUAL;
         end
         default: begin
            if (irq_pulse == 2'b11)  mode_nx = MODE_DUAL;
            else if (irq_pulse[0])   mode_nx = MODE_SOLO0;
            else if (irq_pulse[1])   mode_nx = MODE_SOLO1;
         end
      endcase
   end

   assign mode_chg = (mode_nx != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_DUAL;
         lp_q    <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         mode_q  <= mode_nx;
         lp_q    <= (mode_nx == MODE_SLEEP);
         drain_q <= mode_chg;
      end
   end

   // R3: simultaneous halts in dual mode go straight to low power
   a_r3_both_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DUAL && halt_pulse == 2'b11) |=> (mode_q == MODE_SLEEP));

   // R7: with no halt, dual mode holds whatever the interrupts do
   a_r7_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DUAL && halt_pulse == 2'b00) |=> (mode_q == MODE_DUAL));

   // R6: low power is left only through an interrupt
   a_r6_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SLEEP && irq_pulse == 2'b00) |=> (mode_q == MODE_SLEEP));

   // R9: a drain request always follows a real mode change
   a_r9_drain_after_chg: assert property (@(posedge clk) disable iff (!rst_n)
      drain_q |-> (mode_q != $past(mode_q)));

   // R8: the low-power register tracks the sleep mode
   a_r8_lp_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
      lp_q == (mode_q == MODE_SLEEP));

endmodule

// File: rtl/mt_alloc_ctl.sv
module mt_alloc_ctl
   import mt_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  core_mode_e mode_q,
   input  logic       mode_chg,
   input  logic       drain_done,
   output core_mode_e alloc_q
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         alloc_q <= MODE_DUAL;
      end else if (mode_chg) begin
         pend_q  <= 1'b1;
      end else if (pend_q && drain_done) begin
         pend_q  <= 1'b0;
         alloc_q <= mode_q;
      end
   end

   // R10: with nothing outstanding the allocation cannot move
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> $stable(alloc_q));

   // R10: an acknowledge on a change cycle does not repartition
   a_r10_hold_on_chg: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> $stable(alloc_q));

endmodule

// File: rtl/mt_cap_split.sv
module mt_cap_split
   import mt_mode_pkg::*;
#(
   parameter int QUEUE_DEPTH = 24,
   parameter bit ODD_TO_T0   = 1'b1,
   localparam int CW         = $clog2(QUEUE_DEPTH + 1)
)(
   input  core_mode_e    alloc,
   output logic [CW-1:0] cap0,
   output logic [CW-1:0] cap1
);

   localparam logic [CW-1:0] FULL    = CW'(QUEUE_DEPTH);
   localparam logic [CW-1:0] HALF_LO = CW'(QUEUE_DEPTH / 2);
   localparam logic [CW-1:0] HALF_HI = CW'(QUEUE_DEPTH - QUEUE_DEPTH / 2);

   logic [CW-1:0] split0, split1;

   generate
      if (ODD_TO_T0) begin : g_odd_t0
         assign split0 = HALF_HI;
         assign split1 = HALF_LO;
      end else begin : g_odd_t1
         assign split0 = HALF_LO;
         assign split1 = HALF_HI;
      end
   endgenerate

   always_comb begin
      unique case (alloc)
         MODE_DUAL:  begin cap0 = split0; cap1 = split1; end
         MODE_SOLO0: begin cap0 = FULL;   cap1 = '0;     end
         MODE_SOLO1: begin cap0 = '0;     cap1 = FULL;   end
         default:    begin cap0 = '0;     cap1 = '0;     end
      endcase
   end

   // R11: budgets never exceed the queue
   always_comb begin
      if (!$isunknown(alloc))
         a_r11_cap_bound: assert ((32'(cap0) + 32'(cap1)) <= QUEUE_DEPTH);
   end

endmodule

// File: rtl/mt_mode_ctrl.sv
module mt_mode_ctrl
   import mt_mode_pkg::*;
#(
   parameter int QUEUE_DEPTH = 24,
   parameter bit ODD_TO_T0   = 1'b1,
   localparam int CW         = $clog2(QUEUE_DEPTH + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    halt_pulse,
   input  logic [1:0]    irq_pulse,
   input  logic          drain_done,
   output logic [1:0]    core_mode,
   output logic          low_power_en,
   output logic          drain_req,
   output logic [1:0]    alloc_mode,
   output logic [CW-1:0] cap_t0,
   output logic [CW-1:0] cap_t1
);

   generate
      if (QUEUE_DEPTH < 2) begin : g_bad_depth
         $error("mt_mode_ctrl: QUEUE_DEPTH must be at least 2");
      end
   endgenerate

   core_mode_e mode_q, alloc_q;
   logic       mode_chg, lp_q, drain_q;

   mt_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_pulse (halt_pulse),
      .irq_pulse  (irq_pulse),
      .mode_q     (mode_q),
      .mode_chg   (mode_chg),
      .lp_q       (lp_q),
      .drain_q    (drain_q)
   );

   mt_alloc_ctl u_alloc (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_q     (mode_q),
      .mode_chg   (mode_chg),
      .drain_done (drain_done),
      .alloc_q    (alloc_q)
   );

   mt_cap_split #(
      .QUEUE_DEPTH (QUEUE_DEPTH),
      .ODD_TO_T0   (ODD_TO_T0)
   ) u_caps (
      .alloc (alloc_q),
      .cap0  (cap_t0),
      .cap1  (cap_t1)
   );

   assign core_mode    = mode_q;
   assign low_power_en = lp_q;
   assign drain_req    = drain_q;
   assign alloc_mode   = alloc_q;

endmodule

// File: tb/tb_mt_mode_ctrl.sv
module tb_mt_mode_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 7;
   localparam int CW         = $clog2(DEPTH + 1);
   localparam int NVEC       = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    halt_pulse = '0;
   logic [1:0]    irq_pulse = '0;
   logic          drain_done = 1'b0;
   logic [1:0]    core_mode, alloc_mode;
   logic          low_power_en, drain_req;
   logic [CW-1:0] cap_t0, cap_t1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mt_mode_ctrl #(.QUEUE_DEPTH(DEPTH), .ODD_TO_T0(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .halt_pulse(halt_pulse), .irq_pulse(irq_pulse),
      .drain_done(drain_done), .core_mode(core_mode), .low_power_en(low_power_en),
      .drain_req(drain_req), .alloc_mode(alloc_mode), .cap_t0(cap_t0), .cap_t1(cap_t1)
   );

   // {halt, irq, done, exp_mode, exp_lp, exp_drain, exp_alloc}
   localparam logic [10:0] VEC [NVEC] = '{
      {2'b01, 2'b00, 1'b0, 2'b10, 1'b0, 1'b1, 2'b00},  //  R2 halt t0 in dual
      {2'b00, 2'b00, 1'b1, 2'b10, 1'b0, 1'b0, 2'b10},  //  R10 ack applies solo1
      {2'b00, 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 2'b10},  //  R5 wake halted t0
      {2'b00, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00},  //  R10 ack applies split
      {2'b00, 2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00},  //  R7 irqs in dual ignored
      {2'b10, 2'b00, 1'b0, 2'b01, 1'b0, 1'b1, 2'b00},  //  R2 halt t1 in dual
      {2'b10, 2'b00, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00},  //  R4 halted thread halts again
      {2'b00, 2'b01, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00},  //  R7 irq to active t0
      {2'b00, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, 2'b01},  //  R10 ack
      {2'b00, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, 2'b01},  //  R10 stray ack ignored
      {2'b01, 2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 2'b01},  //  R4 active halts -> sleep
      {2'b11, 2'b00, 1'b0, 2'b11, 1'b1, 1'b0, 2'b01},  //  R6 halts in sleep ignored
      {2'b00, 2'b00, 1'b1, 2'b11, 1'b1, 1'b0, 2'b11},  //  R10 ack -> none
      {2'b00, 2'b10, 1'b0, 2'b10, 1'b0, 1'b1, 2'b11},  //  R6 wake t1 from sleep
      {2'b10, 2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 2'b11},  //  R4 t1 halts -> sleep
      {2'b00, 2'b11, 1'b0, 2'b00, 1'b0, 1'b1, 2'b11},  //  R6 both irqs -> dual
      {2'b11, 2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 2'b11},  //  R3 both halt -> sleep
      {2'b00, 2'b01, 1'b0, 2'b01, 1'b0, 1'b1, 2'b11},  //  R6 wake t0 from sleep
      {2'b01, 2'b10, 1'b0, 2'b10, 1'b0, 1'b1, 2'b11},  //  R5 halt t0 + wake t1
      {2'b10, 2'b00, 1'b1, 2'b11, 1'b1, 1'b1, 2'b11},  //  R10 ack on change ignored
      {2'b00, 2'b00, 1'b0, 2'b11, 1'b1, 1'b0, 2'b11},  //  R9 drain lasts one cycle
      {2'b00, 2'b01, 1'b0, 2'b01, 1'b0, 1'b1, 2'b11},  //  R6 wake t0
      {2'b00, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, 2'b01},  //  R10 ack
      {2'b00, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, 2'b01},  //  R5 wake t1 -> dual
      {2'b00, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00},  //  R11 split budgets
      {2'b01, 2'b00, 1'b0, 2'b10, 1'b0, 1'b1, 2'b00},  //  R2 halt t0
      {2'b10, 2'b01, 1'b0, 2'b01, 1'b0, 1'b1, 2'b00},  //  R5 halt t1 + wake t0
      {2'b00, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, 2'b01}   //  R11 full to t0
   };

   localparam int MREQ [NVEC] = '{2,10,5,10,7,2,4,7,10,10,4,6,10,6,4,6,3,6,5,10,9,6,10,5,11,2,5,11};

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_cap(input logic [1:0] al, input bit t1);
      case (al)
         2'b00:   return t1 ? DEPTH / 2 : DEPTH - DEPTH / 2;
         2'b01:   return t1 ? 0 : DEPTH;
         2'b10:   return t1 ? DEPTH : 0;
         default: return 0;
      endcase
   endfunction

   task automatic chk_all(input int mreq, input logic [1:0] m, input logic lp,
                          input logic dr, input logic [1:0] al);
      chk($sformatf("R%0d mode", mreq), core_mode, m);
      chk("R8 low_power_en", low_power_en, lp);
      chk("R9 drain_req", drain_req, dr);
      chk("R10 alloc_mode", alloc_mode, al);
      chk("R11 cap_t0", cap_t0, exp_cap(al, 1'b0));
      chk("R11 cap_t1", cap_t1, exp_cap(al, 1'b1));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk_all(1, 2'b00, 1'b0, 1'b0, 2'b00);         // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      chk_all(1, 2'b00, 1'b0, 1'b0, 2'b00);         // R1 after release

      for (int i = 0; i < NVEC; i++) begin
         {halt_pulse, irq_pulse, drain_done} = VEC[i][10:6];
         @(negedge clk);
         {halt_pulse, irq_pulse, drain_done} = '0;
         chk_all(MREQ[i], VEC[i][5:4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
      end

      // R4 into sleep with a drain pending, then reset mid-run (R1)
      halt_pulse = 2'b01;
      @(negedge clk);
      halt_pulse = 2'b00;
      chk("R4 mode", core_mode, 2'b11);
      rst_n = 1'b0;
      @(negedge clk);
      chk_all(1, 2'b00, 1'b0, 1'b0, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all(1, 2'b00, 1'b0, 1'b0, 2'b00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule